// File: doc/BRIEF.md
# Scoped Atomic Read-Modify-Write Unit

This block owns a small scratchpad of 32-bit words, addressed by byte, and runs one atomic read-modify-write per request. A request names an operation, a byte address, an operand, a compare value (used only by compare-and-swap), a signed/unsigned select for min and max, and a scope tag. The unit reads the addressed word, computes the new word and writes it back in a single cycle, during which nothing else can reach the storage. It then returns the word that was there before the update.

Requests enter through a valid/ready handshake and are served strictly one at a time. A new request is not accepted until the response to the previous one has been taken, so requests complete in the order they arrive. A misaligned address or an unknown opcode produces an error response and leaves the storage untouched. The scope tag is carried through and echoed on the response. Because this is a single unit with one storage array, every scope gets the same full atomicity.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every storage word holds zero.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the edge where the response is taken (`rsp_valid` and `rsp_ready` both 1), so at most one request is in flight.
- R3: `rsp_valid` is 0 after the acceptance edge and 1 after the next edge. While `rsp_ready` is 0 it stays 1 with `rsp_data`, `rsp_err` and `rsp_scope` unchanged.
- R4: For a valid request, `rsp_data` is the word that was stored before the operation, and `rsp_err` is 0.
- R5: Opcode 0 (add) stores old+operand and opcode 1 (subtract) stores old+(~operand+1). Both wrap modulo 2^32.
- R6: Opcodes 2, 3 and 4 store old AND, OR and XOR operand. Opcode 7 (exchange) stores the operand.
- R7: Opcode 5 (min) and opcode 6 (max) store the smaller or larger of old and operand. They compare as two's-complement numbers when `req_signed` is 1 and as unsigned numbers when it is 0.
- R8: Opcode 8 (compare-and-swap) stores the operand only when old equals `req_compare`, and otherwise leaves the word unchanged.
- R9: A request whose `req_addr[1:0]` is not 00 gives `rsp_err`=1 and `rsp_data`=0, and writes nothing.
- R10: An opcode of 9 to 15 gives `rsp_err`=1 and `rsp_data`=0, and writes nothing.
- R11: `rsp_scope` equals the accepted request's scope (0 wave, 1 workgroup, 2 device, 3 system). The storage result does not depend on the scope.
- R12: The word index is `req_addr[ADDR_W-1:2]`. An operation changes only the word at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 4 | Operation code |
| req_signed | input | 1 | Signed compare for min/max |
| req_scope | input | 2 | Scope tag |
| req_addr | input | ADDR_W | Byte address |
| req_operand | input | DATA_W | Operand / new value |
| req_compare | input | DATA_W | Compare value for compare-and-swap |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Word before the update (0 on error) |
| rsp_err | output | 1 | Misaligned address or unknown opcode |
| rsp_scope | output | 2 | Echo of the request scope |

## Verification
The bound checker watches the handshake on every cycle. It checks that no request is accepted while one is pending, that the response appears exactly two edges after acceptance and holds while stalled, that misaligned addresses and unknown opcodes come back as errors, and that the echoed scope matches the accepted one. The arithmetic itself can only be shown by the bench. This covers wrap-around in add and subtract, signed against unsigned ordering at the sign boundary, compare-and-swap hit and miss, and the fact that a rejected request or a neighbouring address leaves a word intact. The bench compares each returned old value against a model of the storage it keeps itself.

// File: rtl/atom_pkg.sv
package atom_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_MIN  = 4'd5,
        OP_MAX  = 4'd6,
        OP_XCHG = 4'd7,
        OP_CAS  = 4'd8
    } atom_op_e;

    typedef enum logic [1:0] {
        SC_WAVE   = 2'd0,
        SC_GROUP  = 2'd1,
        SC_DEVICE = 2'd2,
        SC_SYSTEM = 2'd3
    } atom_scope_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } atom_state_e;

    localparam logic [3:0] OP_LAST = 4'd8;
endpackage

// File: rtl/atom_alu.sv
module atom_alu #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic              sgn,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] compare,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write
);
    import atom_pkg::*;

    logic [DATA_W-1:0] neg_opnd;
    logic              opnd_less;

    // subtract is built as add of the two's-complement negation
    assign neg_opnd = ~operand + {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (sgn) opnd_less = $signed(operand) < $signed(old_val);
        else     opnd_less = operand < old_val;
    end

    always_comb begin
        new_val  = old_val;
        do_write = 1'b1;
        case (op)
            OP_ADD:  new_val = old_val + operand;
            OP_SUB:  new_val = old_val + neg_opnd;
            OP_AND:  new_val = old_val & operand;
            OP_OR:   new_val = old_val | operand;
            OP_XOR:  new_val = old_val ^ operand;
            OP_MIN:  new_val = opnd_less ? operand : old_val;
            OP_MAX:  new_val = opnd_less ? old_val : operand;
            OP_XCHG: new_val = operand;
            OP_CAS: begin
                new_val  = operand;
                do_write = (old_val == compare);
            end
            default: do_write = 1'b0;
        endcase
    end
endmodule

// File: rtl/atom_word_ram.sv
module atom_word_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                words[g] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic              req_signed,
    input  logic [1:0]        req_scope,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_operand,
    input  logic [DATA_W-1:0] req_compare,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic [1:0]        rsp_scope
);
    import atom_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 2;

    typedef struct packed {
        atom_state_e       st;
        logic [3:0]        op;
        logic              sgn;
        logic [1:0]        scope;
        logic [IDX_W-1:0]  idx;
        logic              bad;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t             r_q, r_d;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] alu_new;
    logic              alu_we;
    logic              mem_we;

    atom_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (r_q.op),
        .sgn      (r_q.sgn),
        .old_val  (ram_rdata),
        .operand  (r_q.opnd),
        .compare  (r_q.cmp),
        .new_val  (alu_new),
        .do_write (alu_we)
    );

    atom_word_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_idx  (r_q.idx),
        .wr_data (alu_new),
        .rd_idx  (r_q.idx),
        .rd_data (ram_rdata)
    );

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_EXEC;
                    r_d.op    = req_op;
                    r_d.sgn   = req_signed;
                    r_d.scope = req_scope;
                    r_d.idx   = req_addr[ADDR_W-1:2];
                    r_d.opnd  = req_operand;
                    r_d.cmp   = req_compare;
                    r_d.bad   = (req_addr[1:0] != 2'b00) || (req_op > OP_LAST);
                end
            end
            ST_EXEC: begin
                // read, modify and write all settle in this one cycle
                mem_we   = !r_q.bad && alu_we;
                r_d.err  = r_q.bad;
                r_d.rdata = r_q.bad ? '0 : ram_rdata;
                r_d.st   = ST_RESP;
            end
            ST_RESP: begin
                if (rsp_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = (r_q.st == ST_RESP);
    assign rsp_data  = r_q.rdata;
    assign rsp_err   = r_q.err;
    assign rsp_scope = r_q.scope;
endmodule

// File: rtl/atom_rmw_checker.sv
module atom_rmw_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_op,
    input logic [1:0]        req_addr_lo,
    input logic [1:0]        req_scope,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_err,
    input logic [1:0]        rsp_scope
);
    logic       fire;
    logic [1:0] scope_seen_q;

    assign fire = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    scope_seen_q <= '0;
        else if (fire) scope_seen_q <= req_scope;
    end

    p_single_flight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !req_ready);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !rsp_valid ##1 rsp_valid);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
                                    && $stable(rsp_err) && $stable(rsp_scope));

    p_misalign_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (req_addr_lo != 2'b00) |=> ##1 (rsp_err && rsp_data == '0));

    p_bad_op_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (req_op > 4'd8) |=> ##1 (rsp_err && rsp_data == '0));

    p_scope_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_scope == scope_seen_q);
endmodule

bind atomic_rmw_unit atom_rmw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr_lo (req_addr[1:0]),
    .req_scope   (req_scope),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_err     (rsp_err),
    .rsp_scope   (rsp_scope)
);

// File: tb/atomic_rmw_unit_test.sv
module atomic_rmw_unit_test;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NW     = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [3:0]        req_op = '0;
    logic              req_signed = 1'b0;
    logic [1:0]        req_scope = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_operand = '0;
    logic [DATA_W-1:0] req_compare = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_err;
    logic [1:0]        rsp_scope;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] model [NW];

    always #10 clk = ~clk;  // 50 MHz

    atomic_rmw_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] model_op(input logic [3:0] op, input logic sgn,
            input logic [31:0] old, input logic [31:0] v, input logic [31:0] c);
        logic lt;
        lt = sgn ? ($signed(v) < $signed(old)) : (v < old);
        case (op)
            4'd0: return {1'b1, old + v};
            4'd1: return {1'b1, old - v};
            4'd2: return {1'b1, old & v};
            4'd3: return {1'b1, old | v};
            4'd4: return {1'b1, old ^ v};
            4'd5: return {1'b1, lt ? v : old};
            4'd6: return {1'b1, lt ? old : v};
            4'd7: return {1'b1, v};
            4'd8: return {old == c, v};
            default: return {1'b0, old};
        endcase
    endfunction

    task automatic run(input logic [3:0] op, input logic sgn, input logic [1:0] sc,
            input logic [ADDR_W-1:0] addr, input logic [31:0] v, input logic [31:0] c,
            input int stall, input string tag);
        logic        bad;
        logic [31:0] old, exp_d;
        logic [32:0] m;
        logic [31:0] held;
        int          wi;
        wi  = int'(addr >> 2);
        bad = (addr[1:0] != 2'b00) || (op > 4'd8);
        old = model[wi];
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_signed = sgn; req_scope = sc;
        req_addr = addr; req_operand = v; req_compare = c;
        chk(req_ready === 1'b1, "R2 ready idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R2 busy", 32'(req_ready), 32'd0);
        chk(rsp_valid === 1'b0, "R3 no early rsp", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R3 rsp valid", 32'(rsp_valid), 32'd1);
        held = rsp_data;
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(rsp_valid === 1'b1 && rsp_data === held, "R3 stall hold", rsp_data, held);
            chk(req_ready === 1'b0, "R2 no accept pending", 32'(req_ready), 32'd0);
        end
        exp_d = bad ? 32'd0 : old;
        chk(rsp_err === bad, {tag, " err"}, 32'(rsp_err), 32'(bad));
        chk(rsp_data === exp_d, {tag, " data"}, rsp_data, exp_d);
        chk(rsp_scope === sc, "R11 scope echo", 32'(rsp_scope), 32'(sc));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R2 released", 32'(req_ready), 32'd1);
        if (!bad) begin
            m = model_op(op, sgn, old, v, c);
            if (m[32]) model[wi] = m[31:0];
        end
    endtask

    // reading a word: OR with zero returns it and writes it back unchanged
    task automatic peek(input int wi, input string tag);
        run(4'd3, 1'b0, 2'd0, ADDR_W'(wi << 2), 32'd0, 32'd0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(rsp_valid === 1'b0, "R1 reset rsp", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < NW; i++) peek(i, "R1 zero word");

        // R5 wrap-around for add and subtract
        run(4'd7, 0, 2'd0, 8'h10, 32'hFFFF_FFFF, 0, 0, "R6 xchg");
        run(4'd0, 0, 2'd1, 8'h10, 32'd1, 0, 1, "R5 add wrap");
        run(4'd1, 0, 2'd2, 8'h10, 32'd1, 0, 2, "R5 sub wrap");
        peek(4, "R5 after sub");
        // R7 signed versus unsigned at the sign boundary
        run(4'd7, 0, 2'd3, 8'h20, 32'h8000_0000, 0, 0, "R6 xchg");
        run(4'd5, 1, 2'd0, 8'h20, 32'd1, 0, 0, "R7 min signed");
        peek(8, "R7 signed min kept");
        run(4'd5, 0, 2'd0, 8'h20, 32'd1, 0, 0, "R7 min unsigned");
        peek(8, "R7 unsigned min took");
        run(4'd6, 1, 2'd1, 8'h20, 32'hFFFF_FFFF, 0, 0, "R7 max signed");
        peek(8, "R7 signed max kept");
        // R8 compare-and-swap miss then hit
        run(4'd8, 0, 2'd2, 8'h30, 32'hAAAA, 32'd5, 0, "R8 cas miss");
        peek(12, "R8 miss unchanged");
        run(4'd8, 0, 2'd2, 8'h30, 32'hAAAA, 32'd0, 0, "R8 cas hit");
        peek(12, "R8 hit stored");
        // R9 misaligned and R10 unknown opcode leave memory intact
        run(4'd7, 0, 2'd0, 8'h31, 32'h1234, 0, 1, "R9 misaligned");
        run(4'd0, 0, 2'd0, 8'h33, 32'h1234, 0, 0, "R9 misaligned");
        peek(12, "R9 unchanged");
        run(4'd9, 0, 2'd3, 8'h30, 32'h1234, 0, 0, "R10 bad op");
        run(4'd15, 0, 2'd3, 8'h30, 32'h1234, 0, 0, "R10 bad op");
        peek(12, "R10 unchanged");
        // R12 neighbours untouched
        peek(11, "R12 neighbour below");
        peek(13, "R12 neighbour above");

        for (int n = 0; n < 400; n++) begin
            logic [3:0]        op;
            logic [ADDR_W-1:0] a;
            op = 4'($urandom_range(0, 10));
            a  = ADDR_W'($urandom_range(0, 7) << 2);
            if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
            run(op, 1'($urandom), 2'($urandom), a, $urandom_range(0, 3) == 0 ? model[a >> 2] : $urandom,
                $urandom_range(0, 1) == 0 ? model[a >> 2] : $urandom, $urandom_range(0, 2),
                "R4 R6 R11 random");
        end
        for (int i = 0; i < 8; i++) peek(i, "R12 final word");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule